// File: doc/BRIEF.md
# Buffered Parallel Port Controller

This block provides 24 general-purpose digital lines in four groups. Two groups are 8 bits wide (port A and port B). Port C is split into a low nibble and a high nibble. A write-only control register sets each group as input or output, in a plain mode with no handshake. Output values are held in latches. Input values are not latched, so a read of an input group returns the live pin levels.

In front of the pins sits a tristate buffer controller. A strap input selects one of two behaviours:

- **Always enabled:** the line drivers are permanently on.
- **Software controlled:** the drivers are switched by software. A mode-set write turns them off, so new output values can be loaded before the lines are driven. A control write with the top bit low turns them back on. A separate buffer register can also switch the drivers on or off at any time, without reprogramming the mode and without clearing the output latches.

Each group's transceiver direction follows that group's direction bit.

Software reaches the block through a small register bus, using a 4-bit offset, write data, a write strobe and a read strobe. A write takes effect at the clock edge where `wr_i` is high. Read data is combinational while `rd_i` is high.

Top module: `pio24_ctrl`

## Requirements
- R1: After reset, all four groups are inputs (`grp_dir_o` = 4'b1111), all output latches are zero, and `buf_en_o` is 0 when `strap_always_en_i` is 0.
- R2: A write to offset 3 with bit 7 = 1 is a mode-set write. It loads the group directions (1 = input, 0 = output) as follows: port A from bit 4, port B from bit 1, port C low from bit 0, port C high from bit 3. The output `grp_dir_o` is packed as [0] = A, [1] = B, [2] = C low, [3] = C high.
- R3: An accepted mode-set write clears all 24 output latches to zero.
- R4: A mode-set write with any of bits 2, 5 or 6 set is rejected. It changes neither the directions, nor the latches, nor the buffer state.
- R5: An accepted mode-set write puts the buffer controller into the disabled state. A write to offset 3 with bit 7 = 0 puts it into the enabled state and leaves the directions and latches unchanged.
- R6: A write to offset 0xC enables the buffers when bit 7 = 0 and disables them when bit 7 = 1. It leaves the directions and latches unchanged.
- R7: When `strap_always_en_i` = 1, `buf_en_o` is 1 in every cycle. When `strap_always_en_i` = 0, `buf_en_o` reflects the buffer controller state.
- R8: Each bit of `pin_oe_o` is 1 exactly when `buf_en_o` = 1 and that line's group is an output. `pin_out_o` always shows the output latches. The line mapping is A = [7:0], B = [15:8], C low = [19:16], C high = [23:20].
- R9: Writes to offsets 0, 1 and 2 load the latches of port A, port B and port C respectively, whatever the current direction. At offset 2, data bits 3:0 go to C low and bits 7:4 go to C high.
- R10: With `rd_i` = 1, a read at offset 0, 1 or 2 returns, for each group, the latch value if the group is an output and the live pin level if it is an input. All other offsets read 0, and `rdata_o` is 0 while `rd_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_always_en_i | input | 1 | 1: buffers always enabled; 0: software controlled |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data |
| pin_in_i | input | 24 | Pin levels seen by the receivers |
| pin_out_o | output | 24 | Output latch values driven towards the pins |
| pin_oe_o | output | 24 | Per-line driver enable |
| grp_dir_o | output | 4 | Per-group transceiver direction, 1 = input |
| buf_en_o | output | 1 | Group buffer enable |

## Verification
The assertions check the following on every cycle:

- the clearing of the latches and the direction bit mapping after an accepted mode-set write;
- that rejected mode-set writes, top-bit-low control writes and buffer-register writes leave the directions and latches untouched;
- the effect of the buffer register on `buf_en_o`;
- the strap forcing `buf_en_o` on;
- that no driver is enabled while the buffers are off.

Only the bench scenarios can show the remaining behaviour. This covers the read path, which mixes live pins and latches per group, and the nibble split of port C on writes. It also covers the sequence of loading output values while the buffers are tristated and then enabling them without losing those values. These are checked against a reference model under random operation mixes, random pin levels and strap changes.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned N_GRP   = 4;
  localparam int unsigned N_LINES = 24;

  localparam logic [ADDR_W-1:0] OFF_PA   = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PB   = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_PC   = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h3;
  localparam logic [ADDR_W-1:0] OFF_BUF  = 4'hC;

  // group order: 0 = A, 1 = B, 2 = C low, 3 = C high
  function automatic int unsigned grp_w(int unsigned g);
    return (g < 2) ? 8 : 4;
  endfunction

  function automatic int unsigned grp_lsb(int unsigned g);
    return (g == 0) ? 0 : (g == 1) ? 8 : (g == 2) ? 16 : 20;
  endfunction

  // position of the group's slice within the write byte
  function automatic int unsigned grp_boff(int unsigned g);
    return (g == 3) ? 4 : 0;
  endfunction
endpackage

// File: rtl/pio_cfg.sv
module pio_cfg
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  output logic [N_GRP-1:0]  dir_o,
  output logic [N_GRP-1:0]  grp_wr_o,
  output logic              mode_set_o,
  output logic              ctrl_low_o,
  output logic              buf_wr_o
);
  logic ctrl_hit, reserved_ok;
  logic [N_GRP-1:0] dir_q;

  assign ctrl_hit    = wr_i && (addr_i == OFF_CTRL);
  assign reserved_ok = (wdata_i[6:5] == 2'b00) && !wdata_i[2];
  assign mode_set_o  = ctrl_hit && wdata_i[7] && reserved_ok;
  assign ctrl_low_o  = ctrl_hit && !wdata_i[7];
  assign buf_wr_o    = wr_i && (addr_i == OFF_BUF);

  assign grp_wr_o[0] = wr_i && (addr_i == OFF_PA);
  assign grp_wr_o[1] = wr_i && (addr_i == OFF_PB);
  assign grp_wr_o[2] = wr_i && (addr_i == OFF_PC);
  assign grp_wr_o[3] = wr_i && (addr_i == OFF_PC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
    end else if (mode_set_o) begin
      dir_q <= {wdata_i[3], wdata_i[0], wdata_i[1], wdata_i[4]};
    end
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/pio_buf_ctrl.sv
module pio_buf_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_always_en_i,
  input  logic mode_set_i,
  input  logic ctrl_low_i,
  input  logic buf_wr_i,
  input  logic buf_val_i,
  output logic buf_en_o
);
  logic dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dis_q <= 1'b1;
    else if (mode_set_i) dis_q <= 1'b1;
    else if (ctrl_low_i) dis_q <= 1'b0;
    else if (buf_wr_i)   dis_q <= buf_val_i;
  end

  assign buf_en_o = strap_always_en_i || !dis_q;
endmodule

// File: rtl/pio_group.sv
module pio_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         is_in_i,
  input  logic         buf_en_i,
  input  logic [W-1:0] pin_in_i,
  output logic [W-1:0] pin_out_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_q <= '0;
    else if (clr_i) lat_q <= '0;
    else if (wr_i)  lat_q <= wdata_i;
  end

  assign pin_out_o = lat_q;
  assign pin_oe_o  = {W{buf_en_i && !is_in_i}};
  assign rd_o      = is_in_i ? pin_in_i : lat_q;
endmodule

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
  import pio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_always_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [N_LINES-1:0] pin_in_i,
  output logic [N_LINES-1:0] pin_out_o,
  output logic [N_LINES-1:0] pin_oe_o,
  output logic [N_GRP-1:0]   grp_dir_o,
  output logic               buf_en_o
);
  logic [N_GRP-1:0]   dir;
  logic [N_GRP-1:0]   grp_wr;
  logic               mode_set, ctrl_low, buf_wr, buf_en;
  logic [N_LINES-1:0] rd_vec;

  pio_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_i       (wr_i),
    .dir_o      (dir),
    .grp_wr_o   (grp_wr),
    .mode_set_o (mode_set),
    .ctrl_low_o (ctrl_low),
    .buf_wr_o   (buf_wr)
  );

  pio_buf_ctrl u_buf (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .strap_always_en_i (strap_always_en_i),
    .mode_set_i        (mode_set),
    .ctrl_low_i        (ctrl_low),
    .buf_wr_i          (buf_wr),
    .buf_val_i         (wdata_i[DATA_W-1]),
    .buf_en_o          (buf_en)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int unsigned W   = grp_w(g);
    localparam int unsigned LSB = grp_lsb(g);
    localparam int unsigned BO  = grp_boff(g);

    pio_group #(.W(W)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (mode_set),
      .wr_i      (grp_wr[g]),
      .wdata_i   (wdata_i[BO +: W]),
      .is_in_i   (dir[g]),
      .buf_en_i  (buf_en),
      .pin_in_i  (pin_in_i[LSB +: W]),
      .pin_out_o (pin_out_o[LSB +: W]),
      .pin_oe_o  (pin_oe_o[LSB +: W]),
      .rd_o      (rd_vec[LSB +: W])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFF_PA:  rdata_o = rd_vec[7:0];
        OFF_PB:  rdata_o = rd_vec[15:8];
        OFF_PC:  rdata_o = rd_vec[23:16];
        default: rdata_o = '0;
      endcase
    end
  end

  assign grp_dir_o = dir;
  assign buf_en_o  = buf_en;
endmodule

// File: rtl/pio24_ctrl_chk.sv
module pio24_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        strap_always_en_i,
  input logic [3:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        wr_i,
  input logic [23:0] pin_out_o,
  input logic [23:0] pin_oe_o,
  input logic [3:0]  grp_dir_o,
  input logic        buf_en_o
);
  logic mode_ok, mode_bad, ctrl_lo, bufc;

  assign mode_ok  = wr_i && addr_i == 4'h3 && wdata_i[7]
                    && wdata_i[6:5] == 2'b00 && !wdata_i[2];
  assign mode_bad = wr_i && addr_i == 4'h3 && wdata_i[7]
                    && (wdata_i[6:5] != 2'b00 || wdata_i[2]);
  assign ctrl_lo  = wr_i && addr_i == 4'h3 && !wdata_i[7];
  assign bufc     = wr_i && addr_i == 4'hC;

  assert_mode_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ok |=> pin_out_o == 24'h0);

  assert_mode_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ok |=> grp_dir_o == {$past(wdata_i[3]), $past(wdata_i[0]),
                              $past(wdata_i[1]), $past(wdata_i[4])});

  assert_bad_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_bad |=> $stable(grp_dir_o) && $stable(pin_out_o));

  assert_ctrl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_lo |=> $stable(grp_dir_o) && $stable(pin_out_o) && buf_en_o);

  assert_buf_reg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bufc |=> $stable(grp_dir_o) && $stable(pin_out_o)
             && (buf_en_o == (strap_always_en_i || !$past(wdata_i[7]))));

  assert_strap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_always_en_i |-> buf_en_o);

  assert_oe_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_en_o |-> pin_oe_o == 24'h0);
endmodule

bind pio24_ctrl pio24_ctrl_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .strap_always_en_i (strap_always_en_i),
  .addr_i            (addr_i),
  .wdata_i           (wdata_i),
  .wr_i              (wr_i),
  .pin_out_o         (pin_out_o),
  .pin_oe_o          (pin_oe_o),
  .grp_dir_o         (grp_dir_o),
  .buf_en_o          (buf_en_o)
);

// File: tb/sim_pio24_ctrl.sv
`timescale 1ns/1ps
module sim_pio24_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_always_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [23:0] pin_in_i = '0;
  logic [23:0] pin_out_o;
  logic [23:0] pin_oe_o;
  logic [3:0]  grp_dir_o;
  logic        buf_en_o;

  int n_chk = 0;
  int n_err = 0;

  // reference model
  logic [3:0]  m_dir = 4'hF;
  logic [23:0] m_lat = '0;
  logic        m_dis = 1'b1;

  always #5 clk_i = ~clk_i;

  pio24_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic m_en();
    return strap_always_en_i || !m_dis;
  endfunction

  function automatic logic [23:0] m_oe();
    logic [23:0] r;
    r[7:0]   = {8{m_en() && !m_dir[0]}};
    r[15:8]  = {8{m_en() && !m_dir[1]}};
    r[19:16] = {4{m_en() && !m_dir[2]}};
    r[23:20] = {4{m_en() && !m_dir[3]}};
    return r;
  endfunction

  function automatic logic [7:0] m_rd(input logic [3:0] a, input logic [23:0] p);
    logic [23:0] v;
    v[7:0]   = m_dir[0] ? p[7:0]   : m_lat[7:0];
    v[15:8]  = m_dir[1] ? p[15:8]  : m_lat[15:8];
    v[19:16] = m_dir[2] ? p[19:16] : m_lat[19:16];
    v[23:20] = m_dir[3] ? p[23:20] : m_lat[23:20];
    case (a)
      4'h0:    return v[7:0];
      4'h1:    return v[15:8];
      4'h2:    return v[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    // model update
    if (a == 4'h3 && d[7] && d[6:5] == 2'b00 && !d[2]) begin
      m_dir = {d[3], d[0], d[1], d[4]};
      m_lat = '0;
      m_dis = 1'b1;
    end else if (a == 4'h3 && !d[7]) begin
      m_dis = 1'b0;
    end else if (a == 4'hC) begin
      m_dis = d[7];
    end else if (a == 4'h0) begin
      m_lat[7:0] = d;
    end else if (a == 4'h1) begin
      m_lat[15:8] = d;
    end else if (a == 4'h2) begin
      m_lat[23:16] = d;
    end
  endtask

  task automatic check_state(input string req);
    #1;
    chk({req, " dir"}, grp_dir_o, m_dir);
    chk({req, " out"}, pin_out_o, m_lat);
    chk({req, " en"},  buf_en_o,  m_en());
    chk({req, " oe"},  pin_oe_o,  m_oe());
  endtask

  task automatic check_read(input string req, input logic [3:0] a, input logic [23:0] p);
    @(negedge clk_i);
    addr_i = a; pin_in_i = p; rd_i = 1'b1;
    #1;
    chk(req, rdata_o, m_rd(a, p));
    rd_i = 1'b0;
    #1;
    chk("R10 idle", rdata_o, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 dir", grp_dir_o, 4'hF);
    chk("R1 out", pin_out_o, 24'h0);
    chk("R1 en",  buf_en_o, 1'b0);
    chk("R1 oe",  pin_oe_o, 24'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_state("R1 after release");
    check_read("R10 input pins A", 4'h0, 24'hA5C3_7E);

    // R2/R5 mode set: A,B out, C in; buffers off
    wr(4'h3, 8'h89);
    check_state("R2 mode 0x89");
    chk("R5 disabled after mode", buf_en_o, 1'b0);
    // load while tristated, then enable: latches kept (R5)
    wr(4'h0, 8'h5A);
    wr(4'h1, 8'hC3);
    check_state("R9 load tristated");
    wr(4'h3, 8'h09);
    check_state("R5 enable keeps latches");
    chk("R5 latch A", pin_out_o[7:0], 8'h5A);
    chk("R8 oe A",    pin_oe_o[7:0], 8'hFF);
    // R6 buffer register
    wr(4'hC, 8'h80);
    check_state("R6 disable");
    chk("R6 off", buf_en_o, 1'b0);
    wr(4'hC, 8'h00);
    check_state("R6 enable");
    chk("R6 latch B kept", pin_out_o[15:8], 8'hC3);
    // R4 illegal mode bits
    wr(4'h3, 8'hA0);
    check_state("R4 bit5 reject");
    wr(4'h3, 8'h84);
    check_state("R4 bit2 reject");
    chk("R4 en unchanged", buf_en_o, 1'b1);
    // R3 mode clear; R9 nibble split of C with all outputs
    wr(4'h3, 8'h80);
    check_state("R3 clear");
    chk("R3 zero", pin_out_o, 24'h0);
    wr(4'h2, 8'h3E);
    check_state("R9 port C");
    chk("R9 C lo", pin_out_o[19:16], 4'hE);
    chk("R9 C hi", pin_out_o[23:20], 4'h3);
    check_read("R10 output latch C", 4'h2, 24'hFFFFFF);
    check_read("R10 ctrl reads 0", 4'h3, 24'hFFFFFF);
    // R7 strap
    @(negedge clk_i); strap_always_en_i = 1'b1;
    check_state("R7 strap on");
    wr(4'hC, 8'h80);
    check_state("R7 strap overrides");
    chk("R7 en", buf_en_o, 1'b1);
    @(negedge clk_i); strap_always_en_i = 1'b0;
    check_state("R7 strap off");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      case (op)
        0, 1, 2: wr(4'(op), d);
        3:       wr(4'h3, {1'b1, 2'b00, d[4:3], 1'b0, d[1:0]});
        4:       wr(4'h3, d | 8'h80);
        5:       wr(4'h3, d & 8'h7F);
        6:       wr(4'hC, d);
        7:       wr(4'($urandom_range(4, 15)), d);
        8: begin
          @(negedge clk_i);
          strap_always_en_i = ($urandom_range(0, 3) == 0);
        end
        default: ;
      endcase
      check_state("R8 random");
      check_read("R10 random", 4'($urandom_range(0, 4)), 24'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule